// File: doc/BRIEF.md
# Funnel-Shift Header Realigner

The realigner sits behind a word-wide memory reader that can only fetch on word boundaries, while the packet header it has to deliver may start on any byte. A start pulse supplies the header's byte address and its length in words. The low address bits give the byte misalignment, which is turned once into a right-shift amount in whole bytes. Input words then stream in over a valid/ready handshake, and aligned header words leave over a second valid/ready handshake.

Each aligned word comes from joining the previously accepted input word (upper half) with the current input word (lower half) into a double-width value, shifting it right and keeping the low word. A misaligned header therefore needs one more input word than it has output words. The first accepted word only primes the holding register, and the extra trailing word supplies the tail of the last output word. A word-aligned header yields a zero shift, so each input word passes straight through and no extra word is fetched. A zero flag and a sign flag follow each emitted word.

Top module: `hdr_realign`

## Requirements
- R1: After reset, out_valid_o, in_ready_o, busy_o, flag_zero_o and flag_sign_o are all 0.
- R2: A start_i pulse while idle with a nonzero length raises busy_o on the next cycle. A start_i pulse while busy is ignored: the words in progress still follow the original offset and length.
- R3: Words are big-endian, with byte 0 in bits 31:24. For byte offset off = start_addr_i[1:0] other than 0, output word k holds stream bytes 4k+off to 4k+off+3, with the lowest-numbered byte in bits 31:24. This equals the low 32 bits of {previous word, current word} shifted right by ((4-off)*8) mod 32.
- R4: For off = 0, output word k equals input word k, and exactly len input words are consumed.
- R5: For off other than 0, exactly len+1 input words are consumed. While the first word has not yet been accepted, out_valid_o stays 0, and in_ready_o does not wait for out_ready_i.
- R6: Exactly len output words are produced. out_last_o is 1 only on the final word. After that word is accepted, busy_o and in_ready_o return to 0.
- R7: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0, so no input word is lost.
- R8: On each accepted output word, flag_zero_o becomes 1 if the word is zero and 0 otherwise, and flag_sign_o becomes bit 31 of the word. Both flags hold their values between accepted output words.
- R9: A start_i pulse with a length of 0 is ignored: busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a header transfer |
| start_addr_i | input | 32 | Byte address of the header start |
| hdr_len_i | input | 8 | Header length in words |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Input word from memory |
| in_ready_o | output | 1 | Input word accepted |
| out_valid_o | output | 1 | Aligned word valid |
| out_data_o | output | 32 | Aligned header word |
| out_last_o | output | 1 | Final word of the header |
| out_ready_i | input | 1 | Downstream accepts the word |
| busy_o | output | 1 | Transfer in progress |
| flag_zero_o | output | 1 | Last emitted word was zero |
| flag_sign_o | output | 1 | Bit 31 of last emitted word |

## Verification
A wrong shift amount or a stale holding register corrupts out_data_o on the first valid output word of a misaligned header. The reference compares every such word, so the error shows within one cycle of that word. A miscounted length or an unconsumed trailing word shows as a wrong out_last_o position, a busy_o that clears too early or too late, or an input count that differs from len or len+1 when the transfer ends. Backpressure faults appear as input words accepted during stall cycles, which shift every later word of the stream.

// File: rtl/realign_pkg.sv
package realign_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} rl_state_e;

  // right shift (bits) that brings byte `off` of the upper word to the top
  function automatic int byte_shift(int off, int bytes);
    return ((bytes - off) * 8) % (bytes * 8);
  endfunction
endpackage

// File: rtl/realign_funnel.sv
module realign_funnel #(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    hi_i,
  input  logic [W-1:0]    lo_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    y_o
);
  assign y_o = W'({hi_i, lo_i} >> sh_i);
endmodule

// File: rtl/realign_ctrl.sv
module realign_ctrl
  import realign_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             busy_o,
  output logic             hold_en_o,
  output logic [SH_W-1:0]  sh_o
);
  rl_state_e        state_q;
  logic [LEN_W-1:0] left_q;
  logic             have_q;
  logic [SH_W-1:0]  sh_q;
  logic             aligned, in_fire, out_fire, launch;
  logic [SH_W-1:0]  sh_next;

  assign sh_next     = SH_W'(byte_shift(int'(off_i), BYTES));
  assign aligned     = (sh_q == '0);
  assign busy_o      = (state_q == ST_RUN);
  assign out_valid_o = busy_o && in_valid_i && (aligned || have_q);
  assign in_ready_o  = busy_o && ((!aligned && !have_q) || out_ready_i);
  assign out_last_o  = out_valid_o && (left_q == LEN_W'(1));
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign launch      = start_i && !busy_o && (len_i != '0);
  assign hold_en_o   = in_fire;
  assign sh_o        = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      have_q  <= 1'b0;
      sh_q    <= '0;
    end else if (launch) begin
      state_q <= ST_RUN;
      left_q  <= len_i;
      have_q  <= 1'b0;
      sh_q    <= sh_next;
    end else if (busy_o) begin
      if (in_fire && !aligned) have_q <= 1'b1;
      if (out_fire) begin
        left_q <= left_q - LEN_W'(1);
        if (left_q == LEN_W'(1)) begin
          state_q <= ST_IDLE;
          have_q  <= 1'b0;
        end
      end
    end
  end

  // R7: a stalled output word blocks further input
  a_r7_stall_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
  // R5: nothing is emitted before the priming word of a misaligned header
  a_r5_prime_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !aligned && !have_q |-> !out_valid_o);
  // R6: final accepted word ends the transfer
  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_last_o |=> !busy_o);
  // R2: start while busy leaves the shift untouched
  a_r2_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !(out_fire && out_last_o) |=> busy_o && $stable(sh_q));
  // R9: zero length never launches
  a_r9_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && (len_i == '0) |=> !busy_o);
endmodule

// File: rtl/realign_flags.sv
module realign_flags #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_i,
  input  logic [W-1:0] res_i,
  output logic         zero_o,
  output logic         sign_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_o <= 1'b0;
      sign_o <= 1'b0;
    end else if (upd_i) begin
      zero_o <= (res_i == '0);
      sign_o <= res_i[W-1];
    end
  end

  // R8: flags move only on an update
  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(zero_o) && $stable(sign_o));
endmodule

// File: rtl/hdr_realign.sv
module hdr_realign #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES),
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic              busy_o,
  output logic              flag_zero_o,
  output logic              flag_sign_o
);
  logic              hold_en;
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] prev_q;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^start_addr_i[ADDR_W-1:OFF_W];

  realign_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .off_i       (start_addr_i[OFF_W-1:0]),
    .len_i       (hdr_len_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .busy_o      (busy_o),
    .hold_en_o   (hold_en),
    .sh_o        (sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (hold_en) prev_q <= in_data_i;
  end

  // zero shift selects the current word: aligned pass-through
  realign_funnel #(.W(DATA_W)) u_funnel (
    .hi_i (prev_q),
    .lo_i (in_data_i),
    .sh_i (sh),
    .y_o  (out_data_o)
  );

  realign_flags #(.W(DATA_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (out_valid_o && out_ready_i),
    .res_i  (out_data_o),
    .zero_o (flag_zero_o),
    .sign_o (flag_sign_o)
  );

  // R1: idle block drives no handshake
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o && !in_ready_o);
  // R8: sign flag tracks the emitted word
  a_r8_sign_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> flag_sign_o == $past(out_data_o[DATA_W-1]));
endmodule

// File: tb/hdr_realign_test.sv
module hdr_realign_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [7:0]  hdr_len_i = '0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o, out_valid_o, out_last_o, busy_o, flag_zero_o, flag_sign_o;
  logic [31:0] out_data_o;
  logic        out_ready_i = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  hdr_realign uut (.*);

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(int seed, int i);
    return (32'h9E3779B9 * (i + 1)) ^ (seed << 11) ^ (32'h00C0FFEE + i * 7);
  endfunction

  task automatic run_hdr(int off, int len, int vp, int rp, int seed, bit zero_data, bit poke);
    logic [31:0] w[$];
    logic [7:0]  b[$];
    logic [31:0] ex[$];
    logic [31:0] pw = '0;
    int nin = len + ((off != 0) ? 1 : 0);
    int ii = 0, ko = 0, cyc = 0;
    bit pf = 0, ifire, ofire;
    for (int i = 0; i < nin; i++) w.push_back(zero_data ? 32'h0 : gen_word(seed, i));
    foreach (w[i]) for (int j = 0; j < 4; j++) b.push_back(w[i][31 - 8*j -: 8]);
    for (int k = 0; k < len; k++)
      ex.push_back({b[off+4*k], b[off+4*k+1], b[off+4*k+2], b[off+4*k+3]});
    @(negedge clk_i);
    start_i = 1'b1;
    start_addr_i = {seed[29:0], off[1:0]};
    hdr_len_i = 8'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    chk(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 32'd1);
    while (ko < len && cyc < 3000) begin
      in_valid_i  = (ii < nin) && (vp == 0 || (cyc % vp) != 0);
      in_data_i   = (ii < nin) ? w[ii] : 32'h0;
      out_ready_i = (rp == 0 || (cyc % rp) != 1);
      if (poke && cyc == 3) begin
        start_i = 1'b1; start_addr_i = 32'h3; hdr_len_i = 8'd1;
      end else start_i = 1'b0;
      #1;
      if (pf) begin
        chk(flag_zero_o === (pw == 0), "R8 zero flag", 32'(flag_zero_o), 32'(pw == 0));
        chk(flag_sign_o === pw[31], "R8 sign flag", 32'(flag_sign_o), 32'(pw[31]));
      end
      if (out_valid_o) begin
        chk(out_data_o === ex[ko], (off == 0) ? "R4 pass-through word" :
            (poke ? "R2/R3 word under ignored start" : "R3 aligned word"), out_data_o, ex[ko]);
        chk(out_last_o === (ko == len - 1), "R6 last flag", 32'(out_last_o), 32'(ko == len - 1));
        if (!out_ready_i)
          chk(in_ready_o === 1'b0, "R7 stall blocks input", 32'(in_ready_o), 32'd0);
      end
      if (off != 0 && ii == 0)
        chk(out_valid_o === 1'b0 && (in_ready_o === 1'b1), "R5 priming word",
            {out_valid_o, in_ready_o}, 32'b01);
      ifire = in_valid_i && in_ready_o;
      ofire = out_valid_o && out_ready_i;
      @(posedge clk_i);
      if (ifire) ii++;
      if (ofire) begin pw = ex[ko]; ko++; end
      pf = ofire;
      cyc++;
      @(negedge clk_i);
    end
    in_valid_i = 1'b0; start_i = 1'b0; out_ready_i = 1'b0;
    #1;
    if (cyc >= 3000) chk(0, "R6 transfer hung", 32'(ko), 32'(len));
    if (pf) chk(flag_zero_o === (pw == 0) && flag_sign_o === pw[31], "R8 final flags",
                {flag_zero_o, flag_sign_o}, {(pw == 0), pw[31]});
    chk(busy_o === 1'b0 && in_ready_o === 1'b0, "R6 idle after last",
        {busy_o, in_ready_o}, 32'd0);
    chk(ii == nin, (off == 0) ? "R4 input count" : "R5 input count", 32'(ii), 32'(nin));
  endtask

  initial begin
    #1;
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b0 && busy_o === 1'b0,
        "R1 reset handshake", {out_valid_o, in_ready_o, busy_o}, 32'd0);
    chk(flag_zero_o === 1'b0 && flag_sign_o === 1'b0, "R1 reset flags",
        {flag_zero_o, flag_sign_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int o = 0; o < 4; o++) run_hdr(o, 5, 0, 0, 10 + o, 0, 0);
    run_hdr(1, 5, 3, 4, 21, 0, 0);
    run_hdr(3, 1, 0, 0, 22, 0, 0);
    run_hdr(2, 7, 0, 2, 23, 0, 0);
    run_hdr(0, 6, 2, 3, 24, 0, 0);
    run_hdr(2, 3, 0, 0, 25, 1, 0);
    run_hdr(1, 6, 0, 3, 26, 0, 1);
    run_hdr(3, 9, 4, 2, 27, 0, 0);

    // R9: zero length start
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = 32'h2; hdr_len_i = 8'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    #1;
    chk(busy_o === 1'b0, "R9 zero length ignored", 32'(busy_o), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule